// File: doc/BRIEF.md
# Dual-Pointer Return Address Stack

This block holds subroutine return addresses for a processor core. One small storage array is shared by two stack pointers, called A and B, and each command names the pointer it uses. A push steps the chosen pointer down by one and then stores the address at the new location. A pop reads the location the pointer then addresses and steps the pointer up by one, so both stacks grow towards lower indices.

A pop can carry a signed discard count. This count is added to the pointer before the read, which drops local data or several whole frames in one return. Each command can also ask for two status flags to be updated. The wrap flag reports that the pointer crossed the end of the array. The collision flag reports that the moved pointer now equals the other pointer.

The core decides when to push or pop. This block only keeps the two pointers, the storage, the flags and the registered return address.

Top module: `ras_dual`

## Requirements
- R1: After reset both pointers are 0, `flag_c` and `flag_z` are 0, `ret_valid` is 0 and `ret_addr` is 0. The first push on either pointer therefore lands in index 255.
- R2: A push (`cmd_valid`=1, `cmd_pop`=0) sets the chosen pointer to (pointer − 1) mod 256 and stores `push_addr` at that new index.
- R3: A pop (`cmd_valid`=1, `cmd_pop`=1) computes the index q = (pointer + offset) mod 256 and reads the stored word at q. The word appears on `ret_addr` with `ret_valid`=1 in the next cycle, and the pointer becomes (q + 1) mod 256.
- R4: Pointers A and B move independently: a command changes only the pointer it selects. Both pointers index the same storage, so a word pushed through A can be popped through B.
- R5: `pop_offset` is a 9-bit two's-complement count in the range −256 to +255. It is added to the pointer before the read. With an offset of 0, a pop returns the most recent push on that pointer.
- R6: When `cmd_wc`=1, `flag_c` takes the wrap result of the command; otherwise it keeps its value. A push wraps exactly when the pointer was 0. A pop wraps when pointer + offset, taken as a plain integer, is below 0, or above 255, or equal to 255 after reduction mod 256.
- R7: When `cmd_wz`=1, `flag_z` becomes 1 if the new value of the chosen pointer equals the unchanged other pointer, and 0 otherwise. This applies to commands on either pointer.
- R8: The flags change only on a valid command whose matching write bit (`cmd_wc` for `flag_c`, `cmd_wz` for `flag_z`) is 1.
- R9: In a cycle after any cycle without a valid pop, `ret_valid` is 0 and `ret_addr` keeps its previous value.
- R10: Command encoding: `cmd_pop`=1 means pop and 0 means push. `cmd_sel_b`=1 selects pointer B and 0 selects pointer A. Push and pop are one field, so they can never be issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_pop | input | 1 | 1 = pop, 0 = push |
| cmd_sel_b | input | 1 | 1 = pointer B, 0 = pointer A |
| cmd_wc | input | 1 | Update the wrap flag with this command |
| cmd_wz | input | 1 | Update the collision flag with this command |
| push_addr | input | AW | Return address stored by a push |
| pop_offset | input | OW | Signed discard count added before a pop |
| ret_addr | output | AW | Word read by the last pop |
| ret_valid | output | 1 | High for one cycle after each pop |
| flag_c | output | 1 | Wrap flag |
| flag_z | output | 1 | Collision flag |

## Verification
The storage is first filled completely by 256 pushes through A. This sweeps pointer A once around the array and checks that the wrap flag is set on the first push only. A directed pop through B with offset −1 then tells apart the reset value, the shared storage, the negative offset and wrap on a pop in a single check. Directed pushes with the collision write bit, placed one step before and exactly on the other pointer, separate a true collision from a near miss. Long runs of random commands with full-range offsets, mixed write bits and idle cycles then compare every pop result and flag against a reference model, which exposes off-by-one errors in pre-decrement and post-increment and flags that change without being asked to.

// File: rtl/ras_dual.sv
`timescale 1ns/1ps
module ras_dual #(
  parameter int AW = 18,
  parameter int PW = 8,
  parameter int OW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic          cmd_pop,
  input  logic          cmd_sel_b,
  input  logic          cmd_wc,
  input  logic          cmd_wz,
  input  logic [AW-1:0] push_addr,
  input  logic [OW-1:0] pop_offset,
  output logic [AW-1:0] ret_addr,
  output logic          ret_valid,
  output logic          flag_c,
  output logic          flag_z
);
  localparam int DEPTH = 1 << PW;
  localparam int XW = ((PW > OW) ? PW : OW) + 2;

  logic [PW-1:0] sp_a, sp_b;
  logic [AW-1:0] store [DEPTH];

  wire [PW-1:0] sp_cur = cmd_sel_b ? sp_b : sp_a;
  wire [PW-1:0] sp_oth = cmd_sel_b ? sp_a : sp_b;

  wire signed [XW-1:0] sum =
      $signed({{(XW-PW){1'b0}}, sp_cur}) + $signed({{(XW-OW){pop_offset[OW-1]}}, pop_offset});

  wire [PW-1:0] rd_idx   = sum[PW-1:0];
  wire [PW-1:0] push_ptr = sp_cur - PW'(1);
  wire [PW-1:0] pop_next = rd_idx + PW'(1);
  wire          pop_wrap = sum[XW-1] | (|sum[XW-2:PW]) | (&sum[PW-1:0]);
  wire          wrap     = cmd_pop ? pop_wrap : (sp_cur == '0);
  wire [PW-1:0] sp_new   = cmd_pop ? pop_next : push_ptr;
  wire          do_push  = cmd_valid & ~cmd_pop;
  wire          do_pop   = cmd_valid & cmd_pop;

  always_ff @(posedge clk) begin
    if (do_push) store[push_ptr] <= push_addr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_a      <= '0;
      sp_b      <= '0;
      flag_c    <= 1'b0;
      flag_z    <= 1'b0;
      ret_valid <= 1'b0;
      ret_addr  <= '0;
    end else begin
      ret_valid <= do_pop;
      if (do_pop) ret_addr <= store[rd_idx];
      if (cmd_valid) begin
        if (cmd_sel_b) sp_b <= sp_new;
        else           sp_a <= sp_new;
        if (cmd_wc) flag_c <= wrap;
        if (cmd_wz) flag_z <= (sp_new == sp_oth);
      end
    end
  end
endmodule

// File: rtl/ras_dual_chk.sv
`timescale 1ns/1ps
module ras_dual_chk #(
  parameter int AW = 18,
  parameter int PW = 8,
  parameter int OW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_pop,
  input logic          cmd_sel_b,
  input logic          cmd_wc,
  input logic          cmd_wz,
  input logic [AW-1:0] push_addr,
  input logic [OW-1:0] pop_offset,
  input logic [AW-1:0] ret_addr,
  input logic          ret_valid,
  input logic          flag_c,
  input logic          flag_z,
  input logic [PW-1:0] sp_a,
  input logic [PW-1:0] sp_b
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (sp_a == '0) && (sp_b == '0) && !flag_c && !flag_z && !ret_valid);

  // R3
  pop_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_pop) |=> ret_valid);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_pop) |=> !ret_valid && $stable(ret_addr));

  // R2
  push_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_pop && !cmd_sel_b) |=> (sp_a == $past(sp_a) - PW'(1)));

  // R4
  other_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_sel_b) |=> $stable(sp_b));

  // R8
  wrap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_wc) |=> $stable(flag_c));

  // R8
  coll_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_wz) |=> $stable(flag_z));

  // R5
  round_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_pop) ##1
    (cmd_valid && cmd_pop && (pop_offset == '0) && (cmd_sel_b == $past(cmd_sel_b)))
    |=> (ret_addr == $past(push_addr, 2)));
endmodule

bind ras_dual ras_dual_chk #(.AW(AW), .PW(PW), .OW(OW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_pop(cmd_pop),
  .cmd_sel_b(cmd_sel_b), .cmd_wc(cmd_wc), .cmd_wz(cmd_wz),
  .push_addr(push_addr), .pop_offset(pop_offset), .ret_addr(ret_addr),
  .ret_valid(ret_valid), .flag_c(flag_c), .flag_z(flag_z),
  .sp_a(sp_a), .sp_b(sp_b)
);

// File: tb/ras_dual_bench.sv
`timescale 1ns/1ps
module ras_dual_bench;
  localparam int AW = 18;
  localparam int PW = 8;
  localparam int OW = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_pop = 1'b0, cmd_sel_b = 1'b0, cmd_wc = 1'b0, cmd_wz = 1'b0;
  logic [AW-1:0] push_addr = '0;
  logic [OW-1:0] pop_offset = '0;
  logic [AW-1:0] ret_addr;
  logic ret_valid, flag_c, flag_z;

  always #2 clk = ~clk;

  ras_dual #(.AW(AW), .PW(PW), .OW(OW)) u_ras_dual (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_pop(cmd_pop),
    .cmd_sel_b(cmd_sel_b), .cmd_wc(cmd_wc), .cmd_wz(cmd_wz),
    .push_addr(push_addr), .pop_offset(pop_offset), .ret_addr(ret_addr),
    .ret_valid(ret_valid), .flag_c(flag_c), .flag_z(flag_z)
  );

  int checks = 0;
  int errors = 0;
  logic [AW-1:0] m_store [256];
  int m_a = 0, m_b = 0;
  logic m_c = 1'b0, m_z = 1'b0;
  logic [AW-1:0] m_ret = '0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic model_wrap(bit pop, int p, logic [OW-1:0] ofs);
    int t;
    if (!pop) return (p == 0);
    t = p + int'($signed(ofs));
    return (t < 0) || (t > 255) || (((t + 512) % 256) == 255);
  endfunction

  task automatic check_outs(string tag, bit pop);
    chk(tag, "ret_valid", 32'(ret_valid), 32'(pop));
    chk(tag, "ret_addr", 32'(ret_addr), 32'(m_ret));
    chk(tag, "flag_c", 32'(flag_c), 32'(m_c));
    chk(tag, "flag_z", 32'(flag_z), 32'(m_z));
  endtask

  task automatic op(bit pop, bit selb, bit wc, bit wz, logic [AW-1:0] a,
                    logic [OW-1:0] ofs, string tag);
    int p, o, np, q;
    logic w;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_pop = pop; cmd_sel_b = selb; cmd_wc = wc; cmd_wz = wz;
    push_addr = a; pop_offset = ofs;
    p = selb ? m_b : m_a;
    o = selb ? m_a : m_b;
    w = model_wrap(pop, p, ofs);
    if (!pop) begin
      np = (p + 255) % 256;
      m_store[np] = a;
    end else begin
      q = (p + int'($signed(ofs)) + 512) % 256;
      m_ret = m_store[q];
      np = (q + 1) % 256;
    end
    if (selb) m_b = np; else m_a = np;
    if (wc) m_c = w;
    if (wz) m_z = (np == o);
    @(negedge clk);
    cmd_valid = 1'b0;
    check_outs(tag, pop);
  endtask

  task automatic idle(string tag);
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_pop = 1'($urandom); cmd_sel_b = 1'($urandom);
    cmd_wc = 1'b1; cmd_wz = 1'b1;
    push_addr = AW'($urandom); pop_offset = OW'($urandom);
    @(negedge clk);
    check_outs(tag, 1'b0);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    chk("R1", "ret_valid", 32'(ret_valid), 0);
    chk("R1", "ret_addr", 32'(ret_addr), 0);
    chk("R1", "flag_c", 32'(flag_c), 0);
    chk("R1", "flag_z", 32'(flag_z), 0);
    rst_n = 1'b1;

    // R6: the first push from pointer 0 wraps, the later ones do not
    op(1'b0, 1'b0, 1'b1, 1'b0, AW'(100), '0, "R6");
    for (int i = 1; i < 256; i++)
      op(1'b0, 1'b0, 1'b1, 1'b0, AW'(100 + i * 7), '0, "R2");

    // R4 R5 R1: B is still 0, offset -1 reads index 255 written through A
    op(1'b1, 1'b1, 1'b1, 1'b0, '0, 9'h1FF, "R4");
    chk("R5", "first push via B", 32'(ret_addr), 32'd100);

    // R7: near miss, then exact collision
    op(1'b0, 1'b1, 1'b0, 1'b1, AW'(18'h3ABCD), '0, "R7");
    op(1'b0, 1'b0, 1'b0, 1'b1, AW'(18'h01234), '0, "R7");
    chk("R7", "collision set", 32'(flag_z), 1);

    // R5: positive discard count
    op(1'b1, 1'b0, 1'b1, 1'b1, '0, 9'd3, "R5");
    // R3: plain pop, zero offset, on B
    op(1'b1, 1'b1, 1'b1, 1'b0, '0, '0, "R3");
    // R8: command without write bits
    op(1'b0, 1'b1, 1'b0, 1'b0, AW'(18'h00055), '0, "R8");
    // R10: push then pop on the same pointer returns the pushed word
    op(1'b0, 1'b1, 1'b0, 1'b0, AW'(18'h2F0F0), '0, "R10");
    op(1'b1, 1'b1, 1'b0, 1'b0, '0, '0, "R10");
    chk("R10", "push then pop", 32'(ret_addr), 32'h2F0F0);
    // R9: idle cycles with write bits and pop request inactive
    idle("R9");
    idle("R9");
    // R6: pop with a large positive offset past the end
    op(1'b1, 1'b0, 1'b1, 1'b0, '0, 9'd255, "R6");

    for (int k = 0; k < 3000; k++) begin
      if (($urandom % 8) == 0) idle("R9");
      else op(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
              AW'($urandom), OW'($urandom), "R3");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule